// File: doc/BRIEF.md
# Multi-level DMA channel arbiter

This block decides which of up to 32 DMA channels is granted service next. Every channel carries a two-bit level assignment, and each of the four levels has its own byte in a 32-bit configuration register. A level byte selects fixed-priority or rotating selection among the channels at that level, gives the level a quality-of-service code, and holds a five-bit channel number that acts as the rotation pointer.

The grant is computed combinationally from the pending requests, the level assignments and the register. It is offered as an index, a one-hot vector, the winning level and that level's QoS code. The requester takes a grant by pulsing `accept`. An accepted grant at a level in rotating mode stores the granted channel number into that level's pointer field on the next clock edge. Software can read the whole register on `cfg_rd`. It can also overwrite the register, unless `cfg_lock` is high. Writing the pointer sets the rotation start point directly.

Top module: `dma_level_arbiter`

## Requirements
- R1: After reset `cfg_rd` reads 0x40404040. Level n uses bits 8n+7..8n. Inside a byte, bit 7 is the rotate enable, bits 6:5 are the QoS code and bits 4:0 are the pointer. Reset therefore leaves every level in fixed-priority mode with QoS 2 and pointer 0.
- R2: When `cfg_wr` is high and `cfg_lock` is low, `cfg_wdata` is stored at the next rising edge and appears on `cfg_rd`.
- R3: When `cfg_lock` is high, `cfg_wr` has no effect on the register.
- R4: `grant_valid` is high exactly when some bit of `req` is high. The winner comes from the highest level that has a pending request, where level 3 is highest and level 0 is lowest. `grant_level` reports that level, and the granted channel is a requesting channel at that level.
- R5: A level in fixed-priority mode (bit 7 = 0) grants its lowest-numbered requesting channel, whatever its pointer field holds.
- R6: A level in rotating mode (bit 7 = 1) grants the first requesting channel found when searching upward from the pointer plus one, wrapping modulo 32.
- R7: When `accept` is high with `grant_valid` high and the winning level is in rotating mode, that level's pointer becomes `grant_idx` at the next edge. The other bits and the other levels are unchanged.
- R8: The pointer field changes only through a register write or the update in R7. Clearing the rotate enable keeps the pointer, and accepted grants at a fixed-priority level leave it unchanged.
- R9: `grant_qos` equals bits 6:5 of the winning level's byte. The codes are 0 background, 1 bandwidth sensitive, 2 latency sensitive and 3 latency critical.
- R10: `grant_onehot` has exactly bit `grant_idx` set while `grant_valid` is high, and is all zero otherwise.
- R11: If an unlocked write and an accepted grant occur in the same cycle, the written value is stored and the pointer update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 32 | Per-channel request bits |
| ch_level | input | 64 | Two-bit level per channel; channel c at bits 2c+1..2c |
| cfg_wr | input | 1 | Register write strobe |
| cfg_lock | input | 1 | Write protect; blocks `cfg_wr` |
| cfg_wdata | input | 32 | Register write data |
| cfg_rd | output | 32 | Current register value |
| accept | input | 1 | Requester takes the offered grant |
| grant_valid | output | 1 | A grant is offered |
| grant_idx | output | 5 | Granted channel number |
| grant_onehot | output | 32 | Granted channel as a one-hot vector |
| grant_level | output | 2 | Level of the granted channel |
| grant_qos | output | 2 | QoS code of the granted level |

## Verification
The hardest case to reach from the ports is the rotating search at every pointer value, including the wrap from channel 31 back to channel 0. It needs a register write to place the pointer and a specific request pattern on the following cycle. The bench sweeps all 32 pointer values against all 32 lead channels at level 0, using a second request five channels further on. Each accepted grant is followed by a readback of the pointer. A directed sequence turns rotation off and back on around accepted fixed-priority grants, to show that the pointer survives. A long pseudo-random phase mixes locked and unlocked writes with accepts, including writes and accepts in the same cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   localparam int CFG_BYTE_W = 8;
   localparam int PTR_W      = 5;
   localparam logic [CFG_BYTE_W-1:0] CFG_BYTE_RESET = 8'h40;

   typedef enum logic [1:0] {
      QOS_BACKGROUND = 2'd0,
      QOS_BANDWIDTH  = 2'd1,
      QOS_LATENCY    = 2'd2,
      QOS_CRITICAL   = 2'd3
   } qos_e;

   typedef struct packed {
      logic             rot_en;
      qos_e             qos;
      logic [PTR_W-1:0] ptr;
   } lvl_cfg_t;
endpackage

// File: rtl/dma_arb_cfg_reg.sv
module dma_arb_cfg_reg
   import dma_arb_pkg::*;
#(
   parameter int N_LVL = 4,
   parameter int CH_W  = 5,
   localparam int LVL_W = $clog2(N_LVL),
   localparam int REG_W = CFG_BYTE_W * N_LVL
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   wr_lock,
   input  logic [REG_W-1:0]       wr_data,
   input  logic                   upd_en,
   input  logic [LVL_W-1:0]       upd_level,
   input  logic [CH_W-1:0]        upd_idx,
   output lvl_cfg_t [N_LVL-1:0]   cfg_q
);
   logic wr_ok;
   assign wr_ok = wr_en && !wr_lock;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < N_LVL; l++) cfg_q[l] <= lvl_cfg_t'(CFG_BYTE_RESET);
      end else if (wr_ok) begin
         for (int l = 0; l < N_LVL; l++) cfg_q[l] <= lvl_cfg_t'(wr_data[l*CFG_BYTE_W +: CFG_BYTE_W]);
      end else if (upd_en && cfg_q[upd_level].rot_en) begin
         cfg_q[upd_level].ptr <= PTR_W'(upd_idx);
      end
   end

   assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lock && !upd_en) |=> $stable(cfg_q));

   assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (REG_W'(cfg_q) == $past(wr_data)));

   for (genvar l = 0; l < N_LVL; l++) begin : g_lvl_chk
      assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_ok && !(upd_en && upd_level == LVL_W'(l))) |=> $stable(cfg_q[l]));
      assert_ptr_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_ok && upd_en && upd_level == LVL_W'(l) && cfg_q[l].rot_en)
         |=> (cfg_q[l].ptr == PTR_W'($past(upd_idx))));
   end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
   parameter int N_CH = 32,
   localparam int CH_W = $clog2(N_CH)
) (
   input  logic [N_CH-1:0] mask,
   input  logic            rot_en,
   input  logic [CH_W-1:0] start,
   output logic            hit,
   output logic [CH_W-1:0] idx
);
   logic [CH_W-1:0] fixed_idx;
   logic [CH_W-1:0] rot_idx;

   always_comb begin
      logic [CH_W-1:0] cand;
      cand      = '0;
      fixed_idx = '0;
      rot_idx   = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (mask[i]) fixed_idx = CH_W'(i);
      end
      for (int i = N_CH - 1; i >= 0; i--) begin
         cand = start + CH_W'(i + 1);
         if (mask[cand]) rot_idx = cand;
      end
   end

   assign hit = |mask;
   assign idx = rot_en ? rot_idx : fixed_idx;
endmodule

// File: rtl/dma_level_arbiter.sv
module dma_level_arbiter
   import dma_arb_pkg::*;
#(
   parameter int N_CH  = 32,
   parameter int N_LVL = 4,
   localparam int CH_W  = $clog2(N_CH),
   localparam int LVL_W = $clog2(N_LVL),
   localparam int REG_W = CFG_BYTE_W * N_LVL
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_CH-1:0]         req,
   input  logic [N_CH*LVL_W-1:0]   ch_level,
   input  logic                    cfg_wr,
   input  logic                    cfg_lock,
   input  logic [REG_W-1:0]        cfg_wdata,
   output logic [REG_W-1:0]        cfg_rd,
   input  logic                    accept,
   output logic                    grant_valid,
   output logic [CH_W-1:0]         grant_idx,
   output logic [N_CH-1:0]         grant_onehot,
   output logic [LVL_W-1:0]        grant_level,
   output logic [1:0]              grant_qos
);
   if (N_CH < 2 || N_CH > (1 << PTR_W) || (N_CH & (N_CH - 1)) != 0) begin : g_bad_nch
      $error("N_CH must be a power of two between 2 and 32");
   end
   if (N_LVL != 2 && N_LVL != 4) begin : g_bad_nlvl
      $error("N_LVL must be 2 or 4");
   end

   lvl_cfg_t [N_LVL-1:0]           cfg_q;
   logic [N_LVL-1:0][N_CH-1:0]     lvl_mask;
   logic [N_LVL-1:0]               lvl_hit;
   logic [N_LVL-1:0][CH_W-1:0]     lvl_idx;
   logic                           upd_en;

   for (genvar l = 0; l < N_LVL; l++) begin : g_level
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign lvl_mask[l][c] = req[c] && (ch_level[c*LVL_W +: LVL_W] == LVL_W'(l));
      end
      dma_arb_pick #(.N_CH(N_CH)) u_pick (
         .mask   (lvl_mask[l]),
         .rot_en (cfg_q[l].rot_en),
         .start  (cfg_q[l].ptr[CH_W-1:0]),
         .hit    (lvl_hit[l]),
         .idx    (lvl_idx[l])
      );
      assign cfg_rd[l*CFG_BYTE_W +: CFG_BYTE_W] = cfg_q[l];
   end

   always_comb begin
      grant_valid = 1'b0;
      grant_level = '0;
      grant_idx   = '0;
      for (int l = 0; l < N_LVL; l++) begin
         if (lvl_hit[l]) begin
            grant_valid = 1'b1;
            grant_level = LVL_W'(l);
            grant_idx   = lvl_idx[l];
         end
      end
   end

   assign grant_onehot = grant_valid ? (N_CH'(1) << grant_idx) : '0;
   assign grant_qos    = grant_valid ? cfg_q[grant_level].qos : 2'd0;
   assign upd_en       = accept && grant_valid;

   dma_arb_cfg_reg #(.N_LVL(N_LVL), .CH_W(CH_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .wr_lock   (cfg_lock),
      .wr_data   (cfg_wdata),
      .upd_en    (upd_en),
      .upd_level (grant_level),
      .upd_idx   (grant_idx),
      .cfg_q     (cfg_q)
   );

   assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ($onehot(grant_onehot) && grant_onehot[grant_idx]));
   assert_idle_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |-> (grant_onehot == '0));
   assert_valid_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) == grant_valid);
   assert_winner_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (req[grant_idx] && ch_level[grant_idx*LVL_W +: LVL_W] == grant_level));
endmodule

// File: tb/dma_level_arbiter_bench.sv
module dma_level_arbiter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] req = '0;
   logic [63:0] ch_level = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_lock = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rd;
   logic        accept = 1'b0;
   logic        grant_valid;
   logic [4:0]  grant_idx;
   logic [31:0] grant_onehot;
   logic [1:0]  grant_level;
   logic [1:0]  grant_qos;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] m_reg;
   string last_tag = "R1";
   logic [31:0] rng = 32'h1234_5678;

   always #4 clk = ~clk;

   dma_level_arbiter u_dma_level_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .ch_level(ch_level),
      .cfg_wr(cfg_wr), .cfg_lock(cfg_lock), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
      .accept(accept), .grant_valid(grant_valid), .grant_idx(grant_idx),
      .grant_onehot(grant_onehot), .grant_level(grant_level), .grant_qos(grant_qos)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rng(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // {valid, level[1:0], idx[4:0]} by distance search, independent of the design
   function automatic logic [7:0] model_pick(input logic [31:0] r, input logic [63:0] lv, input logic [31:0] cfg);
      int best;
      int bd;
      int bi;
      logic [7:0] b;
      best = -1;
      bd = 99;
      bi = 0;
      for (int c = 0; c < 32; c++)
         if (r[c] && int'(lv[2*c +: 2]) > best) best = int'(lv[2*c +: 2]);
      if (best < 0) return 8'h00;
      b = cfg[8*best +: 8];
      for (int c = 0; c < 32; c++) begin
         if (r[c] && int'(lv[2*c +: 2]) == best) begin
            int d;
            d = b[7] ? ((c - int'(b[4:0]) - 1 + 64) % 32) : c;
            if (d < bd) begin bd = d; bi = c; end
         end
      end
      return {1'b1, 2'(best), 5'(bi)};
   endfunction

   task automatic step(input logic [31:0] r, input logic [63:0] lv, input logic we,
                       input logic [31:0] wd, input logic wp, input logic acc);
      logic [7:0] e;
      logic [7:0] b;
      @(negedge clk);
      chk(last_tag, "cfg_rd", cfg_rd, m_reg);
      req = r; ch_level = lv; cfg_wr = we; cfg_wdata = wd; cfg_lock = wp; accept = acc;
      #1;
      e = model_pick(r, lv, m_reg);
      b = m_reg[8*e[6:5] +: 8];
      chk("R4", "grant_valid", 32'(grant_valid), 32'(e[7]));
      if (e[7]) begin
         chk(b[7] ? "R6" : "R5", "grant_idx", 32'(grant_idx), 32'(e[4:0]));
         chk("R4", "grant_level", 32'(grant_level), 32'(e[6:5]));
         chk("R9", "grant_qos", 32'(grant_qos), 32'(b[6:5]));
         chk("R10", "grant_onehot", grant_onehot, 32'(1) << e[4:0]);
      end else begin
         chk("R10", "grant_onehot idle", grant_onehot, 32'h0);
      end
      if (we && !wp) begin
         m_reg = wd;
         last_tag = (acc && e[7]) ? "R11" : "R2";
      end else if (acc && e[7] && b[7]) begin
         m_reg[8*e[6:5] +: 5] = e[4:0];
         last_tag = "R7";
      end else begin
         last_tag = (we && wp) ? "R3" : "R8";
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] all_l1;
      logic [63:0] all_l0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1", "cfg_rd reset", cfg_rd, 32'h4040_4040);
      chk("R1", "grant_valid reset", 32'(grant_valid), 32'h0);
      rst_n = 1'b1;
      m_reg = 32'h4040_4040;
      last_tag = "R1";
      all_l1 = {32{2'b01}};
      all_l0 = '0;

      // R5: fixed priority ignores a non-zero pointer
      step('0, '0, 1'b1, 32'h5F3F_1F5F, 1'b0, 1'b0);
      for (int c = 0; c < 32; c++)
         step((32'(1) << c) | (32'(1) << ((c + 5) % 32)), all_l1, 1'b0, '0, 1'b0, 1'b1);

      // R6 / R7: rotating search from every pointer value with wrap
      for (int p = 0; p < 32; p++) begin
         for (int c = 0; c < 32; c++) begin
            step('0, '0, 1'b1, 32'h4040_40C0 | 32'(p), 1'b0, 1'b0);
            step((32'(1) << c) | (32'(1) << ((c + 5) % 32)), all_l0, 1'b0, '0, 1'b0, 1'b1);
         end
      end

      // R8: pointer survives disable and static accepts, then rotation resumes
      step('0, '0, 1'b1, 32'h40CA_4040, 1'b0, 1'b0);
      step(32'h0000_1008, {32{2'b10}}, 1'b0, '0, 1'b0, 1'b1);
      step('0, '0, 1'b1, 32'h404C_4040, 1'b0, 1'b0);
      step(32'h0000_1008, {32{2'b10}}, 1'b0, '0, 1'b0, 1'b1);
      step(32'h0000_1008, {32{2'b10}}, 1'b0, '0, 1'b0, 1'b1);
      step('0, '0, 1'b0, '0, 1'b0, 1'b0);
      chk("R8", "pointer kept", 32'(cfg_rd[20:16]), 32'd12);
      step('0, '0, 1'b1, 32'h40CC_4040, 1'b0, 1'b0);
      step(32'h0000_1008, {32{2'b10}}, 1'b0, '0, 1'b0, 1'b1);

      // R3: locked writes ignored
      step('0, '0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0);
      step('0, '0, 1'b1, 32'h0000_0000, 1'b1, 1'b0);
      // R11: write beats pointer update
      step('0, '0, 1'b1, 32'hC0C0_C0C0, 1'b0, 1'b0);
      step(32'h0000_00F0, all_l0, 1'b1, 32'hE1A2_0383, 1'b0, 1'b1);

      // mixed pseudo-random phase
      for (int k = 0; k < 4000; k++) begin
         logic [31:0] r;
         logic [63:0] lv;
         logic [31:0] wd;
         logic [31:0] ctl;
         rng = next_rng(rng); r = rng & next_rng(rng ^ 32'h9E37_79B9);
         rng = next_rng(rng); lv[31:0] = rng;
         rng = next_rng(rng); lv[63:32] = rng;
         rng = next_rng(rng); wd = rng;
         rng = next_rng(rng); ctl = rng;
         if (ctl[3:2] == 2'b00) r = '0;
         step(r, lv, ctl[6:4] == 3'b000, wd, ctl[7], ctl[8] | ctl[9]);
      end
      step('0, '0, 1'b0, '0, 1'b0, 1'b0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule